// File: doc/BRIEF.md
# Parallel DAC Bus Sequencer

This block sits on the host side of a 12-bit parallel digital-to-analog converter and runs on a known system clock. It takes commands over a valid/ready handshake and turns each one into a complete bus transaction on the converter's pins. The pins are an active-low chip select, a read/write direction line (high means read), an active-low load strobe, an active-low converter reset with a separate reset-level select, and a 12-bit data bus. The data bus is split into an output word, an output enable and an input word, and the pad ring joins them into a tristated bus.

Every setup, hold and pulse-width minimum of the converter interface is a parameter in nanoseconds. Each one is rounded up to whole clock cycles from the clock-period parameter, and a down-counter enforces it. Five commands are supported: write, write with load, load only, read and reset. A read returns the word sampled from the bus, and it ends only after the converter's bus release window has passed. The host drives the bus only during write transactions.

Top module: `dac_bus_seq`

## Requirements
- R1: While and just after reset, chip select, direction, load strobe and converter reset are all high, the output enable and the response valid are low, and the command ready is high.
- R2: A write (command code 0) drives the direction line low, the output enable high and the data word on the bus one cycle before chip select falls. Chip select then stays low for exactly ceil(50 ns / clock period) cycles, which is 7 at 125 MHz.
- R3: After chip select rises on a write, the direction line stays low and the data word stays driven for ceil(5 ns / period) cycles (1 by default). Then the direction line returns high and the output enable drops. The output enable is never high while the direction line is high.
- R4: A write with load (command code 1) holds the load strobe low in exactly the cycles in which chip select is low. A plain write leaves the load strobe high.
- R5: A load command (code 2) pulls the load strobe low for ceil(50 ns / period) cycles (7). Chip select stays high and the output enable stays low.
- R6: A reset command (code 4) sets the reset-level select to bit 0 of the command data one cycle before the converter reset falls. The reset stays low for ceil(50 ns / period) cycles (7), and the level select keeps its value afterwards.
- R7: A read (command code 3) keeps the direction line high and chip select high for ceil(10 ns / period) cycles (2). It then holds chip select low for the larger of ceil(200 ns / period) and ceil(160 ns / period)+1 cycles (25). The direction line stays high and the output enable stays low throughout.
- R8: The returned read word is the bus input value in the last cycle before chip select rises. Earlier and later values are not taken.
- R9: After chip select rises on a read, ceil(100 ns / period) cycles (13) pass before the response valid goes high for a single cycle with the read word. The command ready returns in that same cycle.
- R10: Command ready is low from acceptance until the transaction ends. Command codes 5 to 7 are accepted and produce no activity on any converter pin, and ready is high again on the next cycle.
- R11: All cycle counts come from the nanosecond parameters and the clock-period parameter, rounded up, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken this cycle if valid |
| cmd_op | input | 3 | Command code: 0 write, 1 write+load, 2 load, 3 read, 4 reset |
| cmd_data | input | 12 | Write word; bit 0 selects mid-scale for reset |
| rsp_valid | output | 1 | One-cycle pulse at the end of a read |
| rsp_data | output | 12 | Word captured by the latest read |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_rd_wr_n | output | 1 | Direction: high read, low write |
| dac_ld_n | output | 1 | Load strobe into the output register, active low |
| dac_clr_n | output | 1 | Converter reset, active low |
| dac_clr_mid | output | 1 | Reset level select: 1 mid-scale, 0 zero-scale |
| dac_bus_out | output | 12 | Word driven toward the converter |
| dac_bus_oe | output | 1 | Output enable for the data bus pads |
| dac_bus_in | input | 12 | Word seen on the data bus pads |

## Verification
The end of a read and the acceptance of the next command can fall in the same cycle. The response valid pulse with the read word appears in exactly the cycle in which command ready returns, so a new command can be taken on that edge. The bench provokes this by offering a write, and also a second read, in the response cycle itself. It judges that the response word is the value from the last chip-select-low cycle, that the pulse lasts one cycle, and that the following write still gets its full setup, pulse and hold while the bus stays undriven for the whole release window.

// File: rtl/dac_bus_pkg.sv
`timescale 1ns/1ps
package dac_bus_pkg;

    localparam logic [2:0] OP_WRITE      = 3'd0;
    localparam logic [2:0] OP_WRITE_LOAD = 3'd1;
    localparam logic [2:0] OP_LOAD       = 3'd2;
    localparam logic [2:0] OP_READ       = 3'd3;
    localparam logic [2:0] OP_RESET      = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSET,
        ST_WCS,
        ST_WHOLD,
        ST_LOAD,
        ST_RSEL,
        ST_RPULSE,
        ST_RSET,
        ST_RCS,
        ST_RREL
    } seq_state_e;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_bus_timer.sv
`timescale 1ns/1ps
module dac_bus_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_d, cnt_q;

    // A load of N makes the current state last N cycles.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R11

endmodule

// File: rtl/dac_bus_rdcap.sv
`timescale 1ns/1ps
module dac_bus_rdcap #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] word
);

    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (cap_en) word_d = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(word_q)); // R8

endmodule

// File: rtl/dac_bus_seq.sv
`timescale 1ns/1ps
module dac_bus_seq #(
    parameter int DW          = 12,
    parameter int CLK_PS      = 8000,
    parameter int T_WCS_NS    = 50,
    parameter int T_WHOLD_NS  = 5,
    parameter int T_RSU_NS    = 10,
    parameter int T_RCS_NS    = 200,
    parameter int T_RVALID_NS = 160,
    parameter int T_RREL_NS   = 100,
    parameter int T_PULSE_NS  = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          dac_cs_n,
    output logic          dac_rd_wr_n,
    output logic          dac_ld_n,
    output logic          dac_clr_n,
    output logic          dac_clr_mid,
    output logic [DW-1:0] dac_bus_out,
    output logic          dac_bus_oe,
    input  logic [DW-1:0] dac_bus_in
);
    import dac_bus_pkg::*;

    localparam int WCS_C   = ns_to_cyc(T_WCS_NS, CLK_PS);
    localparam int WHOLD_C = ns_to_cyc(T_WHOLD_NS, CLK_PS);
    localparam int RSU_C   = ns_to_cyc(T_RSU_NS, CLK_PS);
    localparam int RCS_C   = max2(ns_to_cyc(T_RCS_NS, CLK_PS),
                                  ns_to_cyc(T_RVALID_NS, CLK_PS) + 1);
    localparam int RREL_C  = ns_to_cyc(T_RREL_NS, CLK_PS);
    localparam int PULSE_C = ns_to_cyc(T_PULSE_NS, CLK_PS);
    localparam int MAX_C   = max2(max2(max2(WCS_C, WHOLD_C), max2(RSU_C, RCS_C)),
                                  max2(RREL_C, PULSE_C));
    localparam int TW      = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          cs_n;
        logic          rw;
        logic          ld_n;
        logic          clr_n;
        logic          clr_mid;
        logic          oe;
        logic          with_ld;
        logic [DW-1:0] wdata;
        logic          rsp_v;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          cap_en;

    dac_bus_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dac_bus_rdcap #(.DW(DW)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .bus_in (dac_bus_in),
        .word   (rsp_data)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.rsp_v = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        cap_en      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_WRITE, OP_WRITE_LOAD: begin
                            seq_d.st      = ST_WSET;
                            seq_d.rw      = 1'b0;
                            seq_d.oe      = 1'b1;
                            seq_d.wdata   = cmd_data;
                            seq_d.with_ld = (cmd_op == OP_WRITE_LOAD);
                        end
                        OP_LOAD: begin
                            seq_d.st   = ST_LOAD;
                            seq_d.ld_n = 1'b0;
                            tmr_load   = 1'b1;
                            tmr_val    = TW'(PULSE_C);
                        end
                        OP_READ: begin
                            seq_d.st = ST_RSET;
                            seq_d.rw = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(RSU_C);
                        end
                        OP_RESET: begin
                            seq_d.st      = ST_RSEL;
                            seq_d.clr_mid = cmd_data[0];
                        end
                        default: seq_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_WSET: begin
                seq_d.st   = ST_WCS;
                seq_d.cs_n = 1'b0;
                seq_d.ld_n = !seq_q.with_ld;
                tmr_load   = 1'b1;
                tmr_val    = TW'(WCS_C);
            end
            ST_WCS: begin
                if (tmr_done) begin
                    seq_d.st   = ST_WHOLD;
                    seq_d.cs_n = 1'b1;
                    seq_d.ld_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(WHOLD_C);
                end
            end
            ST_WHOLD: begin
                if (tmr_done) begin
                    seq_d.st = ST_IDLE;
                    seq_d.rw = 1'b1;
                    seq_d.oe = 1'b0;
                end
            end
            ST_LOAD: begin
                if (tmr_done) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.ld_n = 1'b1;
                end
            end
            ST_RSEL: begin
                seq_d.st    = ST_RPULSE;
                seq_d.clr_n = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = TW'(PULSE_C);
            end
            ST_RPULSE: begin
                if (tmr_done) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.clr_n = 1'b1;
                end
            end
            ST_RSET: begin
                if (tmr_done) begin
                    seq_d.st   = ST_RCS;
                    seq_d.cs_n = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(RCS_C);
                end
            end
            ST_RCS: begin
                if (tmr_done) begin
                    cap_en     = 1'b1;
                    seq_d.st   = ST_RREL;
                    seq_d.cs_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(RREL_C);
                end
            end
            ST_RREL: begin
                if (tmr_done) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.rsp_v = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st      <= ST_IDLE;
            seq_q.cs_n    <= 1'b1;
            seq_q.rw      <= 1'b1;
            seq_q.ld_n    <= 1'b1;
            seq_q.clr_n   <= 1'b1;
            seq_q.clr_mid <= 1'b0;
            seq_q.oe      <= 1'b0;
            seq_q.with_ld <= 1'b0;
            seq_q.wdata   <= '0;
            seq_q.rsp_v   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready   = (seq_q.st == ST_IDLE);
    assign rsp_valid   = seq_q.rsp_v;
    assign dac_cs_n    = seq_q.cs_n;
    assign dac_rd_wr_n = seq_q.rw;
    assign dac_ld_n    = seq_q.ld_n;
    assign dac_clr_n   = seq_q.clr_n;
    assign dac_clr_mid = seq_q.clr_mid;
    assign dac_bus_out = seq_q.wdata;
    assign dac_bus_oe  = seq_q.oe;

    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_bus_oe |-> !dac_rd_wr_n); // R3
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_bus_oe && $past(dac_bus_oe)) |-> $stable(dac_bus_out)); // R3
    AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> !cmd_ready); // R10
    AST_CS_RW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !$past(dac_cs_n)) |-> $stable(dac_rd_wr_n)); // R7
    AST_LD_NOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_ld_n && !dac_cs_n) |-> !dac_rd_wr_n); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_CLR_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> $stable(dac_clr_mid)); // R6

endmodule

// File: tb/test_dac_bus_seq.sv
`timescale 1ns/1ps
module test_dac_bus_seq;

    localparam int CLK_PS = 8000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_WCS   = cyc(50);
    localparam int E_HOLD  = cyc(5);
    localparam int E_RSU   = cyc(10);
    localparam int E_RCS   = (cyc(200) > cyc(160) + 1) ? cyc(200) : cyc(160) + 1;
    localparam int E_REL   = cyc(100);
    localparam int E_PULSE = cyc(50);

    logic        clk, rst_n;
    logic        cmd_valid, cmd_ready;
    logic [2:0]  cmd_op;
    logic [11:0] cmd_data;
    logic        rsp_valid;
    logic [11:0] rsp_data;
    logic        dac_cs_n, dac_rd_wr_n, dac_ld_n, dac_clr_n, dac_clr_mid;
    logic [11:0] dac_bus_out;
    logic        dac_bus_oe;
    logic [11:0] dac_bus_in;

    int n_chk  = 0;
    int n_fail = 0;
    bit fin    = 0;

    dac_bus_seq #(.CLK_PS(CLK_PS)) i_dac_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dac_cs_n(dac_cs_n), .dac_rd_wr_n(dac_rd_wr_n), .dac_ld_n(dac_ld_n),
        .dac_clr_n(dac_clr_n), .dac_clr_mid(dac_clr_mid),
        .dac_bus_out(dac_bus_out), .dac_bus_oe(dac_bus_oe), .dac_bus_in(dac_bus_in)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] op, input logic [11:0] data);
        for (int g = 0; g < 200 && !cmd_ready; g++) step();
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1", "cs_n in reset", int'(dac_cs_n), 1);
        chk("R1", "oe in reset", int'(dac_bus_oe), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        step();
        chk("R1", "cs_n", int'(dac_cs_n), 1);
        chk("R1", "rd_wr_n", int'(dac_rd_wr_n), 1);
        chk("R1", "ld_n", int'(dac_ld_n), 1);
        chk("R1", "clr_n", int'(dac_clr_n), 1);
        chk("R1", "oe", int'(dac_bus_oe), 0);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "ready", int'(cmd_ready), 1);
    endtask

    task automatic t_write(input logic [11:0] data, input bit with_ld);
        int n;
        issue(with_ld ? 3'd1 : 3'd0, data);
        chk("R9", "rsp_valid one cycle", int'(rsp_valid), 0);
        chk("R2", "setup rd_wr_n", int'(dac_rd_wr_n), 0);
        chk("R2", "setup oe", int'(dac_bus_oe), 1);
        chk("R2", "setup data", int'(dac_bus_out), int'(data));
        chk("R2", "setup cs_n", int'(dac_cs_n), 1);
        step();
        n = 0;
        while (dac_cs_n == 1'b0 && n < 100) begin
            chk("R4", "ld_n during cs low", int'(dac_ld_n), with_ld ? 0 : 1);
            chk("R10", "ready busy", int'(cmd_ready), 0);
            chk("R3", "data during cs low", int'(dac_bus_out), int'(data));
            n++;
            step();
        end
        chk("R2", "cs low cycles (R11)", n, E_WCS);
        for (int k = 0; k < E_HOLD; k++) begin
            chk("R3", "hold rd_wr_n", int'(dac_rd_wr_n), 0);
            chk("R3", "hold oe", int'(dac_bus_oe), 1);
            chk("R3", "hold data", int'(dac_bus_out), int'(data));
            chk("R4", "ld_n after cs", int'(dac_ld_n), 1);
            step();
        end
        chk("R3", "end rd_wr_n", int'(dac_rd_wr_n), 1);
        chk("R3", "end oe", int'(dac_bus_oe), 0);
        chk("R10", "ready back", int'(cmd_ready), 1);
    endtask

    task automatic t_load();
        int n;
        issue(3'd2, 12'h000);
        n = 0;
        while (dac_ld_n == 1'b0 && n < 100) begin
            chk("R5", "cs_n in load", int'(dac_cs_n), 1);
            chk("R5", "oe in load", int'(dac_bus_oe), 0);
            n++;
            step();
        end
        chk("R5", "ld low cycles (R11)", n, E_PULSE);
        chk("R5", "ready after load", int'(cmd_ready), 1);
    endtask

    task automatic t_clear(input bit mid);
        int n;
        issue(3'd4, {11'h5a5, mid});
        chk("R6", "select before pulse", int'(dac_clr_mid), int'(mid));
        chk("R6", "clr_n not yet low", int'(dac_clr_n), 1);
        step();
        n = 0;
        while (dac_clr_n == 1'b0 && n < 100) begin
            chk("R6", "select during pulse", int'(dac_clr_mid), int'(mid));
            n++;
            step();
        end
        chk("R6", "clr low cycles (R11)", n, E_PULSE);
        chk("R6", "select kept", int'(dac_clr_mid), int'(mid));
        chk("R6", "ready after clear", int'(cmd_ready), 1);
    endtask

    task automatic t_read(input logic [11:0] early, input logic [11:0] last);
        int n, m, r;
        dac_bus_in = early;
        issue(3'd3, 12'h000);
        n = 0;
        while (dac_cs_n == 1'b1 && dac_rd_wr_n == 1'b1 && n < 100) begin
            n++;
            step();
        end
        chk("R7", "setup cycles", n, E_RSU);
        m = 0;
        while (dac_cs_n == 1'b0 && m < 100) begin
            chk("R7", "rd_wr_n during read", int'(dac_rd_wr_n), 1);
            chk("R7", "oe during read", int'(dac_bus_oe), 0);
            m++;
            if (m == E_RCS) dac_bus_in = last;
            step();
        end
        dac_bus_in = early;
        chk("R7", "cs low cycles (R11)", m, E_RCS);
        r = 0;
        while (rsp_valid == 1'b0 && r < 100) begin
            chk("R9", "cs_n in release", int'(dac_cs_n), 1);
            chk("R9", "oe in release", int'(dac_bus_oe), 0);
            chk("R9", "ready in release", int'(cmd_ready), 0);
            r++;
            step();
        end
        chk("R9", "release cycles", r, E_REL);
        chk("R8", "read word", int'(rsp_data), int'(last));
        chk("R9", "ready with response", int'(cmd_ready), 1);
        chk("R9", "rd_wr_n idle", int'(dac_rd_wr_n), 1);
    endtask

    task automatic t_undef(input logic [2:0] op);
        issue(op, 12'hfff);
        chk("R10", "ready after unknown op", int'(cmd_ready), 1);
        chk("R10", "cs_n unknown op", int'(dac_cs_n), 1);
        chk("R10", "ld_n unknown op", int'(dac_ld_n), 1);
        chk("R10", "clr_n unknown op", int'(dac_clr_n), 1);
        chk("R10", "oe unknown op", int'(dac_bus_oe), 0);
        chk("R10", "rd_wr_n unknown op", int'(dac_rd_wr_n), 1);
    endtask

    initial begin
        rst_n      = 1'b0;
        cmd_valid  = 1'b0;
        cmd_op     = 3'd0;
        cmd_data   = 12'h000;
        dac_bus_in = 12'h000;
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        t_write(12'ha5c, 1'b0);
        repeat (2) step();
        t_write(12'h3ff, 1'b1);
        t_load();
        t_clear(1'b1);
        t_clear(1'b0);
        repeat (3) step();
        t_read(12'h0f0, 12'habc);
        t_write(12'h123, 1'b0);
        step();
        t_read(12'h555, 12'h000);
        t_read(12'h000, 12'h800);
        t_undef(3'd7);
        t_undef(3'd5);
        t_write(12'hfff, 1'b1);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule